// File: doc/BRIEF.md
# Time-Multiplexed Two-Stage Sequencer with Intermediate Buffer

This block models a computation that is too large to occupy the device all at once. One shared compute slot holds one of two configurations at a time. A controller steps it through four phases in a loop: load stage A, run stage A, load stage B, run stage B. A load phase is an idle reconfiguration gap of `GAP` clocks. A run phase lasts `RUN_MULT * GAP` clocks, so the work done between gaps is a fixed multiple of the time spent reconfiguring. During the stage A run, each accepted input word is transformed by stage A (add a constant) and written into an on-chip buffer. During the stage B run, the buffer is drained through stage B (XOR with a mask) to the output.

Data never feeds back across a configuration change. Everything stage B needs sits in the buffer, and the two transforms are pure functions of one word. The buffer depth is a parameter. At elaboration it is checked to cover at least one full run of words. When the downstream side holds back, words left in the buffer carry over into the next period. A stage A write that finds the buffer full is dropped, and this raises a sticky error flag.

Top module: `tmux_stage_seq`

## Requirements
- R1: While reset is asserted and right after release: `phase` is 0 (load A), `in_ready` is 0, `out_valid` is 0, `fill_level` is 0 and `ovf_err` is 0.
- R2: `phase` steps through the codes 0 (load A), 1 (run A), 2 (load B), 3 (run B) and then returns to 0. It follows this order forever and skips no phase.
- R3: Each load phase (codes 0 and 2) lasts exactly `GAP` clocks, and `reconfig` is high exactly during these phases.
- R4: Each run phase (codes 1 and 3) lasts exactly `RUN_MULT * GAP` clocks.
- R5: `in_ready` is high exactly in phase 1. A word offered with `in_valid` in any other phase is ignored and does not change `fill_level`.
- R6: A word `x` accepted in phase 1 leaves the block as `((x + ADD_K) mod 2^W) XOR XOR_M`. Words leave in the order they were accepted.
- R7: `out_valid` is high only in phase 3 while `fill_level` is non-zero. A word is removed on each clock where `out_valid` and `out_ready` are both high.
- R8: Words not drained during phase 3 stay in the buffer. They are delivered first in the next phase 3, and `fill_level` reports the count of stored words at all times.
- R9: A phase 1 write that arrives while `fill_level` equals `DEPTH` is dropped. `ovf_err` then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_data | input | W | Input word |
| in_ready | output | 1 | High while stage A runs |
| out_valid | output | 1 | Output word available |
| out_data | output | W | Output word after both stages |
| out_ready | input | 1 | Downstream accepts the output word |
| phase | output | 2 | Current phase code (0 load A, 1 run A, 2 load B, 3 run B) |
| reconfig | output | 1 | High during a reconfiguration gap |
| fill_level | output | clog2(DEPTH+1) | Words held in the buffer |
| ovf_err | output | 1 | Sticky flag: a write was dropped on a full buffer |

## Verification
The data path is tried with four stimulus shapes. A dense stream with a free-running consumer checks the transform and ordering at full rate. A sparse stream, offered in every phase, against a consumer that accepts every other clock shows that words offered outside phase 1 are ignored and that stalls do not reorder data. A period with the consumer stalled for all of phase 3 shows that words carry over into the next period. The next full-rate stream then fills the buffer and shows the dropped writes, the sticky error flag and the delivery of only the words that were kept. Phase codes and their durations are measured over every period, so a wrong gap, a wrong run length or a skipped phase each shows up on its own.

// File: rtl/tmux_pkg.sv
package tmux_pkg;
  typedef enum logic [1:0] {
    PH_LOAD_A = 2'd0,
    PH_RUN_A  = 2'd1,
    PH_LOAD_B = 2'd2,
    PH_RUN_B  = 2'd3
  } phase_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_XOR = 1'b1
  } stage_op_e;
endpackage

// File: rtl/tmux_stage.sv
module tmux_stage #(
  parameter int unsigned W = 8,
  parameter tmux_pkg::stage_op_e OP = tmux_pkg::OP_ADD,
  parameter logic [W-1:0] K = '0
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  generate
    if (OP == tmux_pkg::OP_ADD) begin : g_add
      assign y = x + K;
    end else begin : g_xor
      assign y = x ^ K;
    end
  endgenerate
endmodule

// File: rtl/tmux_phase_ctrl.sv
module tmux_phase_ctrl #(
  parameter int unsigned GAP     = 10,
  parameter int unsigned RUN_LEN = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  output tmux_pkg::phase_e phase
);
  import tmux_pkg::*;

  localparam int unsigned MAXLEN = (RUN_LEN > GAP) ? RUN_LEN : GAP;
  localparam int unsigned CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP - 1);
  localparam logic [CW-1:0] RUN_M1 = CW'(RUN_LEN - 1);

  phase_e         state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           last;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q - 1'b1;
    if (last) begin
      unique case (state_q)
        PH_LOAD_A: begin state_d = PH_RUN_A;  cnt_d = RUN_M1; end
        PH_RUN_A:  begin state_d = PH_LOAD_B; cnt_d = GAP_M1; end
        PH_LOAD_B: begin state_d = PH_RUN_B;  cnt_d = RUN_M1; end
        default:   begin state_d = PH_LOAD_A; cnt_d = GAP_M1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_LOAD_A;
      cnt_q   <= GAP_M1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = state_q;

  // R3
  hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> state_q == $past(state_q));
  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> state_q == phase_e'($past(state_q) + 2'd1));
  // R4
  run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && (state_q == PH_LOAD_A || state_q == PH_LOAD_B)) |=> cnt_q == RUN_M1);
endmodule

// File: rtl/tmux_buffer.sv
module tmux_buffer #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          ovf_q, ovf_d;
  logic          full, push, pop;

  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    lvl_d = lvl_q;
    ovf_d = ovf_q | (wr_en & full);
    if (push) wp_d = (wp_q == LAST_ADDR) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == LAST_ADDR) ? '0 : rp_q + 1'b1;
    if (push && !pop)      lvl_d = lvl_q + 1'b1;
    else if (pop && !push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign level   = lvl_q;
  assign ovf     = ovf_q;

  // R9
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> lvl_q == $past(lvl_q));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LW'(DEPTH));
endmodule

// File: rtl/tmux_stage_seq.sv
module tmux_stage_seq #(
  parameter int unsigned  W        = 8,
  parameter int unsigned  GAP      = 10,
  parameter int unsigned  RUN_MULT = 100,
  parameter int unsigned  DEPTH    = 1024,
  parameter logic [W-1:0] ADD_K    = 8'h35,
  parameter logic [W-1:0] XOR_M    = 8'hA5,
  localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [1:0]    phase,
  output logic          reconfig,
  output logic [LW-1:0] fill_level,
  output logic          ovf_err
);
  import tmux_pkg::*;

  localparam int unsigned RUN_LEN = RUN_MULT * GAP;

  generate
    if (GAP < 1 || RUN_MULT < 1) begin : g_bad_len
      $error("tmux_stage_seq: GAP and RUN_MULT must be at least 1");
    end
    if (DEPTH < RUN_LEN) begin : g_bad_depth
      $error("tmux_stage_seq: DEPTH must hold one full run of words");
    end
  endgenerate

  phase_e        ph;
  logic [W-1:0]  a_out, buf_out;
  logic          wr_en, rd_en, buf_empty;

  tmux_phase_ctrl #(.GAP(GAP), .RUN_LEN(RUN_LEN)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (ph)
  );

  tmux_stage #(.W(W), .OP(OP_ADD), .K(ADD_K)) u_stage_a (
    .x (in_data),
    .y (a_out)
  );

  tmux_buffer #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (a_out),
    .rd_en   (rd_en),
    .rd_data (buf_out),
    .empty   (buf_empty),
    .level   (fill_level),
    .ovf     (ovf_err)
  );

  tmux_stage #(.W(W), .OP(OP_XOR), .K(XOR_M)) u_stage_b (
    .x (buf_out),
    .y (out_data)
  );

  assign in_ready  = (ph == PH_RUN_A);
  assign wr_en     = in_valid && in_ready;
  assign out_valid = (ph == PH_RUN_B) && !buf_empty;
  assign rd_en     = out_valid && out_ready;
  assign reconfig  = (ph == PH_LOAD_A) || (ph == PH_LOAD_B);
  assign phase     = ph;

  // R5
  no_write_outside_run_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_RUN_A) |=> fill_level <= $past(fill_level));
  // R7
  no_read_outside_run_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_RUN_B) |=> fill_level >= $past(fill_level));
endmodule

// File: tb/tmux_stage_seq_test.sv
module tmux_stage_seq_test;
  localparam int unsigned W      = 8;
  localparam int unsigned GAP    = 10;
  localparam int unsigned MULT   = 100;
  localparam int unsigned RUN    = GAP * MULT;
  localparam int unsigned DEPTH  = 1024;
  localparam int unsigned PERIOD = 2 * GAP + 2 * RUN;
  localparam logic [W-1:0] K = 8'h35;
  localparam logic [W-1:0] M = 8'hA5;
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, out_ready;
  logic [W-1:0] in_data;
  logic in_ready, out_valid, reconfig, ovf_err;
  logic [W-1:0] out_data;
  logic [1:0] phase;
  logic [LW-1:0] fill_level;

  always #10 clk = ~clk;

  tmux_stage_seq #(.W(W), .GAP(GAP), .RUN_MULT(MULT), .DEPTH(DEPTH),
                   .ADD_K(K), .XOR_M(M)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .phase(phase), .reconfig(reconfig),
    .fill_level(fill_level), .ovf_err(ovf_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] model_q[$];
  bit model_ovf = 1'b0;
  logic [W-1:0] seed = 8'h00;

  function automatic logic [W-1:0] xf(logic [W-1:0] x);
    logic [W-1:0] s;
    s = x + K;
    return s ^ M;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one full period starting at a negedge at the start of load A.
  // vmode: 0 idle, 1 every clock, 2 every third clock (offered in every phase)
  // rmode: 0 never ready, 1 always ready, 2 every other clock
  task automatic run_period(string tag, int vmode, int rmode);
    int rdy_e = 0, rc_e = 0, v_e = 0, d_e = 0, l_e = 0, o_e = 0, ord_e = 0;
    longint d_act = 0, d_exp = 0;
    int seg = 0, seg_len[4], seg_ph[4];
    int cur = -1;
    for (int c = 0; c < PERIOD; c++) begin
      int ph = int'(phase);
      bit ev, v, r;
      if (in_ready !== (ph == 1)) rdy_e++;
      if (reconfig !== (ph == 0 || ph == 2)) rc_e++;
      ev = (ph == 3) && (model_q.size() > 0);
      if (out_valid !== ev) v_e++;
      else if (ev && out_data !== xf(model_q[0])) begin
        if (d_e == 0) begin d_act = out_data; d_exp = xf(model_q[0]); end
        d_e++;
      end
      if (fill_level !== LW'(model_q.size())) l_e++;
      if (ovf_err !== model_ovf) o_e++;
      if (c == 0) begin
        cur = ph; seg_ph[0] = ph; seg_len[0] = 1;
      end else if (ph == cur) begin
        seg_len[seg]++;
      end else begin
        if (ph != (cur + 1) % 4) ord_e++;
        cur = ph;
        if (seg < 3) begin seg++; seg_ph[seg] = ph; seg_len[seg] = 1; end
        else ord_e++;
      end
      v = (vmode == 1) ? 1'b1 : (vmode == 2) ? (c % 3 == 0) : 1'b0;
      r = (rmode == 1) ? 1'b1 : (rmode == 2) ? (c % 2 == 0) : 1'b0;
      in_valid  = v;
      in_data   = seed;
      out_ready = r;
      if (v) begin
        if (ph == 1) begin
          if (model_q.size() < DEPTH) model_q.push_back(seed);
          else model_ovf = 1'b1;
        end
        seed = seed + 8'd7;
      end
      if (ev && r) void'(model_q.pop_front());
      @(negedge clk);
    end
    in_valid  = 1'b0;
    out_ready = 1'b0;
    chk(rdy_e == 0, "R5", {tag, " in_ready mismatches"}, rdy_e, 0);
    chk(rc_e == 0, "R3", {tag, " reconfig mismatches"}, rc_e, 0);
    chk(v_e == 0, "R7", {tag, " out_valid mismatches"}, v_e, 0);
    chk(d_e == 0, "R6", {tag, " first wrong out_data"}, d_act, d_exp);
    chk(l_e == 0, "R8", {tag, " fill_level mismatches"}, l_e, 0);
    chk(o_e == 0, "R9", {tag, " ovf_err mismatches"}, o_e, 0);
    chk(ord_e == 0 && seg == 3, "R2", {tag, " phase order faults"}, ord_e, 0);
    for (int s = 0; s < 4; s++) begin
      chk(seg_ph[s] == s, "R2", {tag, " phase code of segment"}, seg_ph[s], s);
      if (s % 2 == 0)
        chk(seg_len[s] == GAP, "R3", {tag, " gap length"}, seg_len[s], GAP);
      else
        chk(seg_len[s] == RUN, "R4", {tag, " run length"}, seg_len[s], RUN);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0, "R1", "phase in reset", phase, 0);
    chk(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(fill_level == '0, "R1", "fill_level in reset", fill_level, 0);
    chk(ovf_err == 1'b0, "R1", "ovf_err in reset", ovf_err, 0);
    rst_n = 1'b1;
    chk(reconfig == 1'b1, "R1", "reconfig after release", reconfig, 1);
  endtask

  task automatic t_dense();
    run_period("dense", 1, 1);
    chk(model_q.size() == 0, "R6", "dense drained", model_q.size(), 0);
  endtask

  task automatic t_sparse();
    run_period("sparse", 2, 2);
    chk(model_q.size() == 0, "R5", "sparse drained", model_q.size(), 0);
  endtask

  task automatic t_hold();
    run_period("hold", 1, 0);
    chk(model_q.size() == RUN, "R8", "words kept after stalled run B",
        model_q.size(), RUN);
  endtask

  task automatic t_overflow();
    run_period("overflow", 1, 1);
    chk(model_ovf == 1'b1, "R9", "overflow expected in model", model_ovf, 1);
    chk(model_q.size() == DEPTH - RUN, "R9", "words left after drain",
        model_q.size(), DEPTH - RUN);
  endtask

  task automatic t_tail();
    run_period("tail", 0, 1);
    chk(fill_level == '0, "R8", "buffer empty after tail", fill_level, 0);
    chk(ovf_err == 1'b1, "R9", "ovf_err still set", ovf_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_dense();
    t_sparse();
    t_hold();
    t_overflow();
    t_tail();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule